// File: doc/BRIEF.md
# Three-Channel Compare-Match Tick Timer

The block holds three independent microsecond timers reached through a small synchronous register port with 16-bit data. Each timer has a 32-bit up-counter that advances on a one-cycle `tick_1us` enable pulse, a 32-bit compare value reached as two 16-bit words, and a 16-bit control/status word. When an enabled tick brings the counter to the compare value, the timer records a pending interrupt and adds one to a 4-bit wrapping match-event count. In restart mode the counter then returns to zero, so a compare value of T gives a period of exactly T ticks, which is T microseconds.

Each timer sits in its own 0x100-byte window: timer 0 at 0x000, timer 1 at 0x100, timer 2 at 0x200. Inside a window, control/status is at +0x02, compare high word at +0x04, compare low word at +0x06, counter high word at +0x08 and counter low word at +0x0A. Both counter words are read-only. A read returns its data on `bus_rdata` in the cycle after `bus_rd` is sampled. Unmapped reads return zero.

Top module: `tick_timer_bank`

## Requirements
- R1: Control word fields: bit 0 run, bit 1 restart-on-match, bit 2 clear-event-count strobe, bit 8 interrupt enable, bit 9 clear-pending strobe, bit 10 pending (read-only), bits 7:4 event count (read-only). Bits 3 and 15:11 read as 0, and writes to them are ignored.
- R2: After reset every control word, compare word and counter word reads 0x0000 and every `irq` bit is 0.
- R3: While run is 0 the counter keeps its value, even when ticks arrive.
- R4: On a tick with run set, if counter+1 equals the compare value, a match occurs: pending becomes 1 and the event count goes up by one.
- R5: On a match with restart set, the counter becomes 0, giving a period of T ticks for compare value T. With restart clear, the counter takes the compare value and keeps counting past it.
- R6: Writing a control word with bit 2 set clears that timer's event count. Writing it with bit 2 clear leaves the count unchanged.
- R7: `irq[i]` is 1 exactly when timer i has a pending match and its interrupt enable is set. Setting the enable while a match is pending raises the line.
- R8: Writing a control word with bit 9 set clears pending. Bits 2 and 9 always read back as 0.
- R9: The three timers are independent. Traffic or matches on one timer never change another timer's registers or `irq` bit.
- R10: The event count wraps from 15 to 0. If a match and a write with bit 2 set happen in the same cycle, the count ends at 0.
- R11: The compare high word (+0x04) and low word (+0x06) are written separately. A write to one leaves the other unchanged.
- R12: The counter reads as a high word at +0x08 and a low word at +0x0A, with one cycle of read latency.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_1us | input | 1 | One-cycle count enable, one pulse per microsecond |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | 10 | Byte address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, valid the cycle after `bus_rd` |
| irq | output | 3 | Interrupt request, one bit per timer |

## Verification
The bench places a clear-event-count write in the same cycle as a match. A design that let the increment win would read back a count of 2 instead of 0. It runs seventeen matches, so a design that saturates or widens the count would report 15 or 17 instead of wrapping to 1. It stops the counter at a nonzero value and keeps ticking: a design that ignores the run bit would drift, and one that resets on disable would read zero. Further tests:
- It checks that pending set while interrupts are disabled still raises the line once the enable is written.
- It writes one compare half and reads the other back unchanged.
- It writes all ones to a control word, which exposes reserved bits or strobe bits that are stored instead of discarded.

// File: rtl/tick_timer_pkg.sv
// Package: shared constants for the tick timer bank.
// Holds the control-word bit positions and the register offsets inside
// one timer's address window. Every other file in the block reads these.
package tick_timer_pkg;

    // Control/status word bit positions
    localparam int CTL_RUN     = 0;
    localparam int CTL_RESTART = 1;
    localparam int CTL_CLR_EV  = 2;
    localparam int CTL_EV_LSB  = 4;
    localparam int CTL_IE      = 8;
    localparam int CTL_CLR_PND = 9;
    localparam int CTL_PEND    = 10;

    // Byte offsets inside one timer window
    localparam logic [15:0] OFS_CTRL  = 16'h0002;
    localparam logic [15:0] OFS_CMP_H = 16'h0004;
    localparam logic [15:0] OFS_CMP_L = 16'h0006;
    localparam logic [15:0] OFS_CNT_H = 16'h0008;
    localparam logic [15:0] OFS_CNT_L = 16'h000A;

endpackage

// File: rtl/tt_count_unit.sv
// Module: tt_count_unit
// Holds one timer's up-counter and its compare value.
// Assumes tick is a single-cycle enable pulse. A match is signalled
// combinationally on the tick that takes the counter to the compare value.
// The counter is 2*DW bits wide and the compare value is written in DW halves.
module tt_count_unit #(
    parameter int DW = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            tick,
    input  logic            run,
    input  logic            restart,
    input  logic            wr_cmp_hi,
    input  logic            wr_cmp_lo,
    input  logic [DW-1:0]   wdata,
    output logic [2*DW-1:0] cnt,
    output logic [2*DW-1:0] cmp,
    output logic            match
);
    localparam int CW = 2 * DW;

    logic [CW-1:0] cnt_q;
    logic [CW-1:0] cmp_q;
    logic [CW-1:0] cnt_inc;
    logic          step;

    assign step    = tick && run;
    assign cnt_inc = cnt_q + 1'b1;
    assign match   = step && (cnt_inc == cmp_q);

    // Compare register: each half is written independently
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmp_q <= '0;
        end else begin
            if (wr_cmp_hi) cmp_q[CW-1:DW] <= wdata;
            if (wr_cmp_lo) cmp_q[DW-1:0]  <= wdata;
        end
    end

    // Counter: advances on enabled ticks and returns to zero on a match in restart mode
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (step) begin
            cnt_q <= (match && restart) ? '0 : cnt_inc;
        end
    end

    assign cnt = cnt_q;
    assign cmp = cmp_q;

endmodule

// File: rtl/tt_ctrl_unit.sv
// Module: tt_ctrl_unit
// Holds one timer's control/status word: the run, restart and interrupt-enable
// bits, the pending flag and the wrapping event count.
// Assumes match is a one-cycle pulse from the count unit.
// A match outranks a clear-pending write, so no event is lost.
// A clear-event-count write outranks a match.
module tt_ctrl_unit
    import tick_timer_pkg::*;
#(
    parameter int DW  = 16,
    parameter int EVW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_ctrl,
    input  logic [DW-1:0] wdata,
    input  logic          match,
    output logic          run,
    output logic          restart,
    output logic          ie,
    output logic          pend,
    output logic [EVW-1:0] evcnt,
    output logic          irq,
    output logic [DW-1:0] ctrl_rd
);
    logic           run_q, restart_q, ie_q, pend_q;
    logic [EVW-1:0] ev_q;
    logic           unused_wbits;

    assign unused_wbits = ^wdata;

    // Configuration bits, loaded on any control write
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q     <= 1'b0;
            restart_q <= 1'b0;
            ie_q      <= 1'b0;
        end else if (wr_ctrl) begin
            run_q     <= wdata[CTL_RUN];
            restart_q <= wdata[CTL_RESTART];
            ie_q      <= wdata[CTL_IE];
        end
    end

    // Event count: clear strobe first, otherwise step on a match with wrap-around
    always_ff @(posedge clk) begin
        if (!rst_n)                          ev_q <= '0;
        else if (wr_ctrl && wdata[CTL_CLR_EV]) ev_q <= '0;
        else if (match)                      ev_q <= ev_q + 1'b1;
    end

    // Pending flag: set on a match, cleared by the write-one strobe
    always_ff @(posedge clk) begin
        if (!rst_n)                            pend_q <= 1'b0;
        else if (match)                        pend_q <= 1'b1;
        else if (wr_ctrl && wdata[CTL_CLR_PND]) pend_q <= 1'b0;
    end

    // Read view: strobe and reserved bits read as zero
    always_comb begin
        ctrl_rd                         = '0;
        ctrl_rd[CTL_RUN]                = run_q;
        ctrl_rd[CTL_RESTART]            = restart_q;
        ctrl_rd[CTL_EV_LSB +: EVW]      = ev_q;
        ctrl_rd[CTL_IE]                 = ie_q;
        ctrl_rd[CTL_PEND]               = pend_q;
    end

    assign run     = run_q;
    assign restart = restart_q;
    assign ie      = ie_q;
    assign pend    = pend_q;
    assign evcnt   = ev_q;
    assign irq     = pend_q && ie_q;

endmodule

// File: rtl/tick_timer_bank.sv
// Module: tick_timer_bank (top)
// A bank of N_TIMERS compare-match timers behind a synchronous 16-bit register port.
// Each timer owns a 2**STRIDE_LOG2-byte window. Reads are registered, with a latency of one cycle.
// Assumes tick_1us is a one-cycle pulse in the clk domain.
module tick_timer_bank
    import tick_timer_pkg::*;
#(
    parameter int N_TIMERS    = 3,
    parameter int ADDR_W      = 10,
    parameter int STRIDE_LOG2 = 8,
    parameter int DW          = 16,
    parameter int EVW         = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_1us,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DW-1:0]     bus_wdata,
    output logic [DW-1:0]     bus_rdata,
    output logic [N_TIMERS-1:0] irq
);
    localparam int CW    = 2 * DW;
    localparam int IDX_W = ADDR_W - STRIDE_LOG2;

    logic [IDX_W-1:0] idx;
    logic [15:0]      ofs;

    logic [N_TIMERS-1:0]          run_w, restart_w, ie_w, pend_w, match_w;
    logic [N_TIMERS-1:0][CW-1:0]  cnt_w, cmp_w;
    logic [N_TIMERS-1:0][EVW-1:0] ev_w;
    logic [N_TIMERS-1:0][DW-1:0]  ctrl_w;
    logic [N_TIMERS-1:0]          wr_ctrl_w, wr_cmph_w, wr_cmpl_w;
    logic [DW-1:0]                rd_next;
    logic [DW-1:0]                rdata_q;

    assign idx = bus_addr[ADDR_W-1:STRIDE_LOG2];
    assign ofs = 16'(bus_addr[STRIDE_LOG2-1:0]);

    for (genvar g = 0; g < N_TIMERS; g++) begin : g_tmr
        logic hit;
        assign hit          = (idx == IDX_W'(g));
        assign wr_ctrl_w[g] = bus_wr && hit && (ofs == OFS_CTRL);
        assign wr_cmph_w[g] = bus_wr && hit && (ofs == OFS_CMP_H);
        assign wr_cmpl_w[g] = bus_wr && hit && (ofs == OFS_CMP_L);

        tt_count_unit #(.DW(DW)) u_cnt (
            .clk       (clk),
            .rst_n     (rst_n),
            .tick      (tick_1us),
            .run       (run_w[g]),
            .restart   (restart_w[g]),
            .wr_cmp_hi (wr_cmph_w[g]),
            .wr_cmp_lo (wr_cmpl_w[g]),
            .wdata     (bus_wdata),
            .cnt       (cnt_w[g]),
            .cmp       (cmp_w[g]),
            .match     (match_w[g])
        );

        tt_ctrl_unit #(.DW(DW), .EVW(EVW)) u_ctl (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_ctrl (wr_ctrl_w[g]),
            .wdata   (bus_wdata),
            .match   (match_w[g]),
            .run     (run_w[g]),
            .restart (restart_w[g]),
            .ie      (ie_w[g]),
            .pend    (pend_w[g]),
            .evcnt   (ev_w[g]),
            .irq     (irq[g]),
            .ctrl_rd (ctrl_w[g])
        );
    end

    // Read select: pick the addressed register of the addressed timer
    always_comb begin
        rd_next = '0;
        for (int i = 0; i < N_TIMERS; i++) begin
            if (idx == IDX_W'(i)) begin
                case (ofs)
                    OFS_CTRL:  rd_next = ctrl_w[i];
                    OFS_CMP_H: rd_next = cmp_w[i][CW-1:DW];
                    OFS_CMP_L: rd_next = cmp_w[i][DW-1:0];
                    OFS_CNT_H: rd_next = cnt_w[i][CW-1:DW];
                    OFS_CNT_L: rd_next = cnt_w[i][DW-1:0];
                    default:   rd_next = '0;
                endcase
            end
        end
    end

    // Read data register: captured on a read strobe and held otherwise
    always_ff @(posedge clk) begin
        if (!rst_n)      rdata_q <= '0;
        else if (bus_rd) rdata_q <= rd_next;
    end

    assign bus_rdata = rdata_q;

endmodule

// File: rtl/tick_timer_bank_chk.sv
// Module: tick_timer_bank_chk
// Assertion checker bound to tick_timer_bank.
// It decodes the bus on its own and watches each timer's count, match and status signals.
module tick_timer_bank_chk
    import tick_timer_pkg::*;
#(
    parameter int N_TIMERS    = 3,
    parameter int ADDR_W      = 10,
    parameter int STRIDE_LOG2 = 8,
    parameter int DW          = 16,
    parameter int EVW         = 4
) (
    input logic                              clk,
    input logic                              rst_n,
    input logic                              bus_wr,
    input logic [ADDR_W-1:0]                 bus_addr,
    input logic [DW-1:0]                     bus_wdata,
    input logic [N_TIMERS-1:0]               run,
    input logic [N_TIMERS-1:0]               restart,
    input logic [N_TIMERS-1:0]               pend,
    input logic [N_TIMERS-1:0]               match,
    input logic [N_TIMERS-1:0][2*DW-1:0]     cnt,
    input logic [N_TIMERS-1:0][EVW-1:0]      evcnt
);
    logic unused_chk;
    assign unused_chk = ^bus_wdata;

    for (genvar g = 0; g < N_TIMERS; g++) begin : g_chk
        logic ctl_wr;
        assign ctl_wr = bus_wr &&
            (bus_addr == ADDR_W'((g << STRIDE_LOG2) + int'(OFS_CTRL)));

        // R3: a stopped counter keeps its value
        a_r3_hold_when_stopped: assert property (@(posedge clk) disable iff (!rst_n)
            !run[g] |=> cnt[g] == $past(cnt[g]));

        // R5: a match in restart mode leaves the counter at zero
        a_r5_restart_to_zero: assert property (@(posedge clk) disable iff (!rst_n)
            (match[g] && restart[g]) |=> cnt[g] == '0);

        // R4: a match leaves pending set
        a_r4_match_sets_pend: assert property (@(posedge clk) disable iff (!rst_n)
            match[g] |=> pend[g]);

        // R8: a clear-pending write with no match drops pending
        a_r8_clear_pend: assert property (@(posedge clk) disable iff (!rst_n)
            (ctl_wr && bus_wdata[CTL_CLR_PND] && !match[g]) |=> !pend[g]);

        // R10: a clear-event-count write outranks a match
        a_r10_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
            (ctl_wr && bus_wdata[CTL_CLR_EV]) |=> evcnt[g] == '0);

        // R10: the event count only steps by one or returns to zero
        a_r10_count_step: assert property (@(posedge clk) disable iff (!rst_n)
            !$stable(evcnt[g]) |-> (evcnt[g] == $past(evcnt[g]) + 1'b1 || evcnt[g] == '0));
    end

endmodule

bind tick_timer_bank tick_timer_bank_chk #(
    .N_TIMERS    (N_TIMERS),
    .ADDR_W      (ADDR_W),
    .STRIDE_LOG2 (STRIDE_LOG2),
    .DW          (DW),
    .EVW         (EVW)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .run       (run_w),
    .restart   (restart_w),
    .pend      (pend_w),
    .match     (match_w),
    .cnt       (cnt_w),
    .evcnt     (ev_w)
);

// File: tb/tick_timer_bank_bench.sv
`timescale 1ns/1ps
// Scoreboard bench for tick_timer_bank.
// The read driver pushes expected words into a queue. A monitor compares each read result against the queue.
module tick_timer_bank_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_1us = 1'b0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [9:0]  bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic [2:0]  irq;

    int n_checks = 0;
    int n_fails  = 0;
    bit done = 1'b0;

    logic [15:0] exp_q[$];
    string       tag_q[$];
    logic        rd_q = 1'b0;

    always #2.5 clk = ~clk;

    tick_timer_bank u_tick_timer_bank (
        .clk(clk), .rst_n(rst_n), .tick_1us(tick_1us),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
    );

    // Expected control word from its fields
    function automatic logic [15:0] ctl(bit pend, bit ie, int ev, bit rst, bit run);
        logic [15:0] v;
        v = '0;
        v[10] = pend; v[8] = ie; v[7:4] = 4'(ev); v[1] = rst; v[0] = run;
        return v;
    endfunction

    always @(posedge clk) rd_q <= bus_rd;

    // Monitor: compare read data with the scoreboard queue
    always @(negedge clk) begin
        if (rd_q) begin
            logic [15:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            n_checks++;
            if (bus_rdata !== e) begin
                n_fails++;
                $display("FAIL %s: read got %h expected %h", t, bus_rdata, e);
            end
        end
    end

    task automatic bus_write(input logic [9:0] a, input logic [15:0] d);
        @(negedge clk); bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk); bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [9:0] a, input logic [15:0] e, input string t);
        @(negedge clk); bus_rd = 1'b1; bus_addr = a;
        exp_q.push_back(e); tag_q.push_back(t);
        @(negedge clk); bus_rd = 1'b0;
    endtask

    task automatic ticks(input int n);
        repeat (n) begin @(negedge clk); tick_1us = 1'b1; end
        @(negedge clk); tick_1us = 1'b0;
    endtask

    task automatic check_irq(input logic [2:0] e, input string t);
        @(negedge clk);
        n_checks++;
        if (irq !== e) begin
            n_fails++;
            $display("FAIL %s: irq got %b expected %b", t, irq, e);
        end
    endtask

    // Watchdog: a hung run counts as a failure
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R2: reset state
        check_irq(3'b000, "R2 irq after reset");
        bus_read(10'h002, 16'h0000, "R2 ctrl0 reset");
        bus_read(10'h102, 16'h0000, "R2 ctrl1 reset");
        bus_read(10'h206, 16'h0000, "R2 cmp2 lo reset");
        bus_read(10'h00A, 16'h0000, "R2 cnt0 lo reset");

        // R4 R5 R7: timer 0, compare 5, restart, interrupt enabled
        bus_write(10'h004, 16'h0000);
        bus_write(10'h006, 16'h0005);
        bus_write(10'h002, 16'h0103);
        ticks(4);
        check_irq(3'b000, "R4 no match before compare");
        bus_read(10'h00A, 16'h0004, "R12 cnt0 lo before match");
        ticks(1);
        check_irq(3'b001, "R7 irq on match");
        bus_read(10'h002, ctl(1, 1, 1, 1, 1), "R4 pend and count after match");
        bus_read(10'h00A, 16'h0000, "R5 restart to zero");

        // R8: clear pending, strobe bits read zero
        bus_write(10'h002, 16'h0303);
        check_irq(3'b000, "R8 irq cleared");
        bus_read(10'h002, ctl(0, 1, 1, 1, 1), "R8 clear reads zero");

        // R3: stop at a nonzero count and keep ticking
        ticks(2);
        bus_write(10'h002, 16'h0102);
        ticks(3);
        bus_read(10'h00A, 16'h0002, "R3 counter held");
        bus_read(10'h008, 16'h0000, "R12 cnt0 hi");

        // R10: wrap after 17 matches in total (16 more from count 2 after 78 ticks)
        bus_write(10'h002, 16'h0103);
        ticks(78);
        bus_read(10'h002, ctl(1, 1, 1, 1, 1), "R10 event count wrap");
        bus_read(10'h00A, 16'h0000, "R5 period of T ticks");

        // R6: clear with bit 2, no effect with bit 2 clear
        bus_write(10'h002, 16'h0107);
        bus_read(10'h002, ctl(1, 1, 0, 1, 1), "R6 clear event count");
        ticks(5);
        bus_write(10'h002, 16'h0103);
        bus_read(10'h002, ctl(1, 1, 1, 1, 1), "R6 write zero keeps count");

        // R10: match and clear in the same cycle
        ticks(4);
        @(negedge clk);
        tick_1us = 1'b1; bus_wr = 1'b1; bus_addr = 10'h002; bus_wdata = 16'h0107;
        @(negedge clk);
        tick_1us = 1'b0; bus_wr = 1'b0;
        bus_read(10'h002, ctl(1, 1, 0, 1, 1), "R10 clear wins over match");

        // R5 R7: timer 1, no restart, interrupt disabled
        bus_write(10'h104, 16'h0000);
        bus_write(10'h106, 16'h0003);
        bus_write(10'h102, 16'h0001);
        ticks(3);
        check_irq(3'b001, "R7 irq1 gated by enable");
        bus_read(10'h102, ctl(1, 0, 1, 0, 1), "R4 timer1 pending");
        ticks(2);
        bus_read(10'h10A, 16'h0005, "R5 counts past match");
        bus_write(10'h102, 16'h0101);
        check_irq(3'b011, "R7 enable with pending raises irq1");

        // R9 R11: timer 2 untouched, then split compare writes
        bus_read(10'h202, 16'h0000, "R9 timer2 untouched");
        bus_read(10'h20A, 16'h0000, "R9 timer2 counter idle");
        bus_write(10'h204, 16'hABCD);
        bus_read(10'h204, 16'hABCD, "R11 cmp hi written");
        bus_read(10'h206, 16'h0000, "R11 cmp lo unchanged");
        bus_write(10'h206, 16'h1234);
        bus_read(10'h204, 16'hABCD, "R11 cmp hi kept");
        bus_read(10'h206, 16'h1234, "R11 cmp lo written");

        // R1 R8: all-ones write keeps only storable bits
        bus_write(10'h202, 16'hFFFF);
        bus_read(10'h202, ctl(0, 1, 0, 1, 1), "R1 reserved and strobe bits");
        bus_read(10'h006, 16'h0005, "R9 timer0 compare kept");
        check_irq(3'b011, "R9 irq2 still low");

        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

endmodule